// File: doc/BRIEF.md
# Line Write-Enable Generator with Odd/Even Stream Split

This block sits between a horizontal sample-rate converter and one or two field memories. For every video line it issues write-enable pulses so that the memory stores exactly the programmed number of luma samples, whatever the rate converter and the incoming line enable do. A line begins when the (optionally one-cycle delayed) input enable rises. While that enable is high, a write pulse is issued in each cycle where the converter flags a valid sample. When the converter produces fewer samples than the input enable spans, cycles are simply left without a pulse. When the input enable ends before the count is met, dummy pulses are issued on every clock until it is met. When the count is met before the input enable ends, further samples are dropped without a pulse.

In split mode the stored samples alternate between two memories. Even-indexed samples go to the main enable and odd-indexed samples to the odd enable. Each stream then receives the programmed count, so the line holds twice as many samples. To keep chroma groups of four samples together, the odd stream drops its first two samples and receives two dummy pulses after the last sample of the line. Two phase bits each add one cycle of delay: one on the input enable path and one on the output enable path.

States: IDLE (waiting for a line start), RUN (input enable active, counting valid samples), PAD (input enable ended early, one dummy pulse per clock), TAIL (split mode only, odd-stream dummy pulses), HOLD (count met, waiting for the input enable to end). Transitions: IDLE→RUN on a rising input enable; RUN→PAD when the enable drops before the count is met; RUN/PAD/IDLE→TAIL when the count is met in split mode; RUN/IDLE→HOLD when the count is met in normal mode with the enable high; RUN/PAD→IDLE when the count is met in normal mode with the enable low; TAIL→HOLD or TAIL→IDLE after the two dummy pulses, chosen by the enable level; HOLD→IDLE when the enable drops.

Top module: `line_we_dist`

## Requirements
- R1: In normal mode (split_en=0) each line produces exactly 4×(prog_cnt+1) pulses on we_main.
- R2: When the input enable is high in a cycle with smp_vld=1 and the count is not yet met, we_main pulses for that sample. If the final sample arrives in the last high cycle of the enable, no extra pulse follows.
- R3: From the first cycle in which the aligned input enable is low before the count is met, a pulse is issued on every clock until the count is met.
- R4: Once the count is met, no pulse is issued on either enable until a new line starts, even while the input enable stays high and smp_vld=1.
- R5: A cycle with the input enable high and smp_vld=0 produces no pulse.
- R6: In split mode (split_en=1) the line stores 8×(prog_cnt+1) sample slots, indexed from 0. Even slots pulse we_main, so we_main carries 4×(prog_cnt+1) pulses; the two enables never pulse in the same cycle.
- R7: In split mode odd slots 1 and 3 produce no pulse, odd slots from 5 upward pulse we_odd, and we_odd pulses on the two clocks after the last slot. This gives 4×(prog_cnt+1) pulses on we_odd per line.
- R8: Pulses appear one clock after the sampling edge. in_shift=1 delays the input enable by one clock relative to smp_vld; out_shift=1 delays both outputs by one more clock.
- R9: During reset both enables are low; in normal mode we_odd stays low.
- R10: A line starts only on a rising edge of the aligned input enable while idle. The slot count then restarts from zero, so a new line one cycle after the previous one ended produces its full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (output-rate) clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wei_in | input | 1 | Input line write enable |
| smp_vld | input | 1 | Converter has a sample this cycle |
| prog_cnt | input | PROG_W | Programmed line length in units of four luma samples, minus one |
| split_en | input | 1 | 1 = odd/even stream split |
| in_shift | input | 1 | 1 = delay input enable by one clock |
| out_shift | input | 1 | 1 = delay output enables by one clock |
| we_main | output | 1 | Main (or even-stream) write enable |
| we_odd | output | 1 | Odd-stream write enable |

## Verification
Two things can happen in the same cycle: the final required sample is counted, and the input enable drops. Depending on which comes first, the line ends normally, enters padding, or enters the absorbing hold. The bench provokes this by holding the enable high for exactly as many valid samples as required, then for more, then for fewer, and with a sparse valid pattern whose last valid sample lands one cycle before the fall. It judges each case by comparing both enables on every clock against a behavioural model and by checking the pulse total per line. A second coincidence, the last split-mode slot meeting the start of the odd-stream dummies, is judged the same way with an early enable fall.

// File: rtl/lwd_pkg.sv
package lwd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_PAD,
        ST_TAIL,
        ST_HOLD
    } lwd_state_t;
endpackage

// File: rtl/lwd_in_align.sv
module lwd_in_align (
    input  logic clk,
    input  logic rst_n,
    input  logic wei_in,
    input  logic in_shift,
    output logic wei_eff,
    output logic rise
);
    logic wei_d1;
    logic eff_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wei_d1   <= 1'b0;
            eff_prev <= 1'b0;
        end else begin
            wei_d1   <= wei_in;
            eff_prev <= wei_eff;
        end
    end

    assign wei_eff = in_shift ? wei_d1 : wei_in;
    assign rise    = wei_eff & ~eff_prev;
endmodule

// File: rtl/lwd_line_fsm.sv
module lwd_line_fsm
    import lwd_pkg::*;
#(
    parameter int PROG_W     = 8,
    parameter int LUMA_SHIFT = 2,
    parameter int ODD_SKIP   = 2,
    localparam int CNT_W     = PROG_W + LUMA_SHIFT + 2,
    localparam int TAIL_W    = $clog2(ODD_SKIP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wei_eff,
    input  logic              rise,
    input  logic              smp_vld,
    input  logic [PROG_W-1:0] prog_cnt,
    input  logic              split_en,
    output lwd_state_t        st,
    output logic              slot,
    output logic [CNT_W-1:0]  slot_idx,
    output logic [CNT_W-1:0]  target,
    output logic              tail_act
);
    lwd_state_t        nxt;
    lwd_state_t        done_st;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  base;
    logic [TAIL_W-1:0] tail_q;
    logic              last;

    assign base     = CNT_W'(prog_cnt) + CNT_W'(1);
    assign target   = split_en ? (base << (LUMA_SHIFT + 1)) : (base << LUMA_SHIFT);
    assign slot_idx = (st == ST_IDLE) ? '0 : cnt_q;
    assign last     = (slot_idx + CNT_W'(1)) == target;
    assign tail_act = (st == ST_TAIL);
    assign done_st  = split_en ? ST_TAIL : (wei_eff ? ST_HOLD : ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt_q  <= '0;
            tail_q <= '0;
        end else begin
            st     <= nxt;
            cnt_q  <= slot_idx + CNT_W'(slot);
            tail_q <= (st == ST_TAIL) ? tail_q + TAIL_W'(1) : '0;
        end
    end

    // per-state slot output
    always_comb begin
        slot = 1'b0;
        unique case (st)
            ST_IDLE: slot = rise & smp_vld;
            ST_RUN:  slot = wei_eff ? smp_vld : 1'b1;
            ST_PAD:  slot = 1'b1;
            ST_TAIL: slot = 1'b0;
            ST_HOLD: slot = 1'b0;
            default: slot = 1'b0;
        endcase
    end

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: if (rise) nxt = (slot && last) ? done_st : ST_RUN;
            ST_RUN: begin
                if (slot && last)  nxt = done_st;
                else if (!wei_eff) nxt = ST_PAD;
            end
            ST_PAD:  if (last) nxt = done_st;
            ST_TAIL: if (tail_q == TAIL_W'(ODD_SKIP - 1)) nxt = wei_eff ? ST_HOLD : ST_IDLE;
            ST_HOLD: if (!wei_eff) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/lwd_stream_route.sv
module lwd_stream_route #(
    parameter int CNT_W    = 12,
    parameter int ODD_SKIP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot,
    input  logic [CNT_W-1:0] slot_idx,
    input  logic             tail_act,
    input  logic             split_en,
    input  logic             out_shift,
    output logic             main_raw,
    output logic             odd_raw,
    output logic             we_main,
    output logic             we_odd
);
    localparam logic [CNT_W-1:0] FIRST_ODD = CNT_W'(2 * ODD_SKIP);

    logic [1:0] raw;
    logic [1:0] lane_out;

    assign main_raw = slot & (~split_en | ~slot_idx[0]);
    assign odd_raw  = split_en & ((slot & slot_idx[0] & (slot_idx >= FIRST_ODD)) | tail_act);
    assign raw      = {odd_raw, main_raw};

    for (genvar s = 0; s < 2; s++) begin : g_lane
        logic d1;
        logic d2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d1 <= 1'b0;
                d2 <= 1'b0;
            end else begin
                d1 <= raw[s];
                d2 <= d1;
            end
        end
        assign lane_out[s] = out_shift ? d2 : d1;
    end

    assign we_main = lane_out[0];
    assign we_odd  = lane_out[1];
endmodule

// File: rtl/line_we_dist.sv
module line_we_dist
    import lwd_pkg::*;
#(
    parameter int PROG_W     = 8,
    parameter int LUMA_SHIFT = 2,
    parameter int ODD_SKIP   = 2,
    localparam int CNT_W     = PROG_W + LUMA_SHIFT + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wei_in,
    input  logic              smp_vld,
    input  logic [PROG_W-1:0] prog_cnt,
    input  logic              split_en,
    input  logic              in_shift,
    input  logic              out_shift,
    output logic              we_main,
    output logic              we_odd
);
    logic             wei_eff;
    logic             rise;
    lwd_state_t       st;
    logic             slot;
    logic [CNT_W-1:0] slot_idx;
    logic [CNT_W-1:0] target;
    logic             tail_act;
    logic             main_raw;
    logic             odd_raw;

    lwd_in_align u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .wei_in   (wei_in),
        .in_shift (in_shift),
        .wei_eff  (wei_eff),
        .rise     (rise)
    );

    lwd_line_fsm #(
        .PROG_W     (PROG_W),
        .LUMA_SHIFT (LUMA_SHIFT),
        .ODD_SKIP   (ODD_SKIP)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wei_eff  (wei_eff),
        .rise     (rise),
        .smp_vld  (smp_vld),
        .prog_cnt (prog_cnt),
        .split_en (split_en),
        .st       (st),
        .slot     (slot),
        .slot_idx (slot_idx),
        .target   (target),
        .tail_act (tail_act)
    );

    lwd_stream_route #(
        .CNT_W    (CNT_W),
        .ODD_SKIP (ODD_SKIP)
    ) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot      (slot),
        .slot_idx  (slot_idx),
        .tail_act  (tail_act),
        .split_en  (split_en),
        .out_shift (out_shift),
        .main_raw  (main_raw),
        .odd_raw   (odd_raw),
        .we_main   (we_main),
        .we_odd    (we_odd)
    );
endmodule

// File: rtl/lwd_checker.sv
module lwd_checker
    import lwd_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input lwd_state_t       st,
    input logic [CNT_W-1:0] slot_idx,
    input logic [CNT_W-1:0] target,
    input logic             main_raw,
    input logic             odd_raw,
    input logic             rise,
    input logic             split_en,
    input logic             we_odd
);
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |-> (slot_idx <= target));

    assert_pad_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAD) |=> (st == ST_IDLE || slot_idx == $past(slot_idx) + CNT_W'(1)));

    assert_hold_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> (!main_raw && !odd_raw));

    assert_split_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_raw && odd_raw));

    assert_odd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!split_en && !$past(split_en) && !$past(split_en, 2)) |-> !we_odd);

    assert_idle_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !rise) |=> (st == ST_IDLE));
endmodule

bind line_we_dist lwd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .slot_idx (slot_idx),
    .target   (target),
    .main_raw (main_raw),
    .odd_raw  (odd_raw),
    .rise     (rise),
    .split_en (split_en),
    .we_odd   (we_odd)
);

// File: tb/tb_line_we_dist.sv
module tb_line_we_dist;
    logic       clk = 1'b0;
    logic       rst_n, wei_in, smp_vld, split_en, in_shift, out_shift;
    logic [7:0] prog_cnt;
    wire        we_main, we_odd;

    always #10 clk = ~clk;

    line_we_dist dut (
        .clk(clk), .rst_n(rst_n), .wei_in(wei_in), .smp_vld(smp_vld),
        .prog_cnt(prog_cnt), .split_en(split_en), .in_shift(in_shift),
        .out_shift(out_shift), .we_main(we_main), .we_odd(we_odd)
    );

    int    n_chk = 0, n_fail = 0, cyc = 0, pm = 0, po = 0;
    string tag = "R9";
    bit    chk_on = 1'b0;

    // behavioural reference: modes 0 idle, 1 run, 2 pad, 3 tail, 4 hold
    int m_mode = 0, m_cnt = 0, m_tail = 0;
    bit m_wd1 = 0, m_wprev = 0, m_o1m = 0, m_o2m = 0, m_o1o = 0, m_o2o = 0;

    always @(posedge clk) begin
        bit weff, rise, sl, mr, orw;
        int idx, tgt, nm, dn;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_tail = 0; m_wd1 = 0; m_wprev = 0;
            m_o1m = 0; m_o2m = 0; m_o1o = 0; m_o2o = 0;
        end else begin
            weff = in_shift ? m_wd1 : wei_in;
            rise = weff && !m_wprev;
            idx  = (m_mode == 0) ? 0 : m_cnt;
            tgt  = (int'(prog_cnt) + 1) * (split_en ? 8 : 4);
            dn   = split_en ? 3 : (weff ? 4 : 0);
            sl   = 0;
            nm   = m_mode;
            case (m_mode)
                0: if (rise) begin sl = smp_vld; nm = (sl && idx + 1 == tgt) ? dn : 1; end
                1: begin
                    sl = weff ? smp_vld : 1'b1;
                    if (sl && idx + 1 == tgt) nm = dn;
                    else if (!weff) nm = 2;
                end
                2: begin sl = 1; if (idx + 1 == tgt) nm = dn; end
                3: if (m_tail == 1) nm = weff ? 4 : 0;
                default: if (!weff) nm = 0;
            endcase
            mr  = sl && (!split_en || idx % 2 == 0);
            orw = split_en && ((sl && idx % 2 == 1 && idx >= 4) || m_mode == 3);
            m_tail = (m_mode == 3) ? m_tail + 1 : 0;
            m_cnt  = idx + int'(sl);
            m_mode = nm;
            m_o2m = m_o1m; m_o1m = mr;
            m_o2o = m_o1o; m_o1o = orw;
            m_wd1 = wei_in; m_wprev = weff;
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        bit em, eo;
        if (chk_on) begin
            em = out_shift ? m_o2m : m_o1m;
            eo = out_shift ? m_o2o : m_o1o;
            n_chk++;
            if (we_main !== em || we_odd !== eo) begin
                n_fail++;
                $display("FAIL %s cycle %0d: we_main=%b we_odd=%b expected %b %b",
                         tag, cyc, we_main, we_odd, em, eo);
            end
            if (we_main) pm++;
            if (we_odd)  po++;
        end
    end

    task automatic check_val(input string t, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", t, got, exp);
        end
    endtask

    // pat 0: all valid, 1: alternate, 2: every third missing
    task automatic line(input int hi, input int pat, input int gap);
        for (int i = 0; i < hi; i++) begin
            @(negedge clk);
            wei_in  = 1'b1;
            smp_vld = (pat == 0) ? 1'b1 : (pat == 1) ? (i % 2 == 0) : (i % 3 != 2);
        end
        @(negedge clk);
        wei_in  = 1'b0;
        smp_vld = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic mark(output int bm, output int bo);
        #1; bm = pm; bo = po;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int bm, bo, am, ao;
        rst_n = 0; wei_in = 0; smp_vld = 0; split_en = 0;
        in_shift = 0; out_shift = 0; prog_cnt = 8'd1;
        repeat (3) @(negedge clk);
        check_val("R9 reset we_main", int'(we_main), 0);
        check_val("R9 reset we_odd", int'(we_odd), 0);
        rst_n = 1;
        chk_on = 1;
        repeat (4) @(negedge clk);

        tag = "R2"; mark(bm, bo);
        line(8, 0, 20); mark(am, ao);
        check_val("R1 line length normal", am - bm, 8);
        check_val("R9 odd idle in normal mode", ao - bo, 0);

        tag = "R3"; mark(bm, bo);
        line(10, 1, 20); mark(am, ao);
        check_val("R3 padded line length", am - bm, 8);

        tag = "R4"; mark(bm, bo);
        line(20, 0, 20); mark(am, ao);
        check_val("R4 excess absorbed", am - bm, 8);

        tag = "R10"; mark(bm, bo);
        line(20, 0, 0);
        line(8, 1, 20); mark(am, ao);
        check_val("R10 back-to-back lines", am - bm, 16);

        prog_cnt = 8'd2; repeat (4) @(negedge clk);
        tag = "R5"; mark(bm, bo);
        line(18, 2, 20); mark(am, ao);
        check_val("R5 sparse valid line length", am - bm, 12);

        prog_cnt = 8'd0; split_en = 1; repeat (4) @(negedge clk);
        tag = "R6"; mark(bm, bo);
        line(8, 0, 20); mark(am, ao);
        check_val("R6 even stream length", am - bm, 4);
        check_val("R7 odd stream length", ao - bo, 4);

        prog_cnt = 8'd1; repeat (4) @(negedge clk);
        tag = "R7"; mark(bm, bo);
        line(5, 0, 30); mark(am, ao);
        check_val("R6 even stream padded", am - bm, 8);
        check_val("R7 odd stream padded", ao - bo, 8);

        split_en = 0; in_shift = 1; out_shift = 1; repeat (4) @(negedge clk);
        tag = "R8"; mark(bm, bo);
        line(12, 1, 20); mark(am, ao);
        check_val("R8 shifted line length", am - bm, 8);
        check_val("R8 shifted odd quiet", ao - bo, 0);

        repeat (4) @(negedge clk);
        chk_on = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule